// File: doc/BRIEF.md
# Boot Swap Configuration Evaluator

At start-up this block decides which of two address regions of program memory becomes active. It walks a table of swap records in configuration memory through a simple word-read port. Each record is four 32-bit words: a location word, a status word, a marker word and a CRC word. A record counts only when its status word carries the "valid" magic value, its marker names a region, and its CRC word matches a CRC-32 over the first three words. Among valid records of a table, the one with the highest index governs.

The primary table is searched first. A second, backup table is searched only when the primary holds no valid record. When the search ends, the block presents a 2-bit swap code, a flag naming the table that supplied the decision, the record index, and a level `done` signal. A 4-bit arm field gates the whole evaluation. Unless it holds the one enabling pattern, no memory is read and the swap code is forced to "no swap".

Top module: `swap_cfg_eval`

## Requirements
- R1: After reset, `done` is 0, `cfg_code` is 00, `from_copy` is 0 and `win_idx` is 0.
- R2: Evaluation is armed only when `swap_arm` equals 4'b1010. Any other value, for example 4'b0101 or 4'b0000, issues no memory read. `done` then rises with `cfg_code`=00, `from_copy`=0 and `win_idx`=0.
- R3: A record is accepted only when its status word (byte offset +4) equals 32'h43211234. Any other value, including 32'h57B5327F, rejects the record.
- R4: A marker word (offset +8) of 32'h00000055 yields `cfg_code`=01 (region A active). A marker word of 32'h000000AA yields `cfg_code`=10 (region B active). Any other marker value rejects the record, and `cfg_code` never shows 11.
- R5: A record is accepted only when its CRC word (offset +0xC) equals the reflected CRC-32 (polynomial 0x04C11DB7, initial value and final XOR 0xFFFFFFFF). The CRC runs over the location word (offset 0), the status word and the marker word, in that order, each word least significant byte first.
- R6: Within a table, the valid record with the highest index decides. `win_idx` reports that index (0 to 31).
- R7: The backup table is consulted only when the primary table has no valid record. `from_copy` is 1 exactly when the decision came from the backup table.
- R8: When neither table holds a valid record, `done` rises with `cfg_code`=00, `from_copy`=0 and `win_idx`=0.
- R9: A `start` pulse clears `done` in the following cycle. Once `done` is high, it stays high, with the outputs unchanged, until the next `start` or reset.
- R10: Record x of a table is read at byte addresses base + x*0x10 + {0,4,8,0xC}. The primary base is `ORIG_BASE` and the backup base is `COPY_BASE`. Read data is expected one cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an evaluation |
| swap_arm | input | 4 | Arm field; 4'b1010 enables evaluation |
| mem_rd | output | 1 | Word read strobe |
| mem_addr | output | 32 | Byte address of the word being read |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| cfg_code | output | 2 | 00 none, 01 region A, 10 region B |
| from_copy | output | 1 | 1 when the backup table decided |
| win_idx | output | 7 | Index of the governing record |
| done | output | 1 | Evaluation finished (level) |

## Verification
The hardest situation to reach is a fallback to the backup table in which the primary table is not simply empty. Here the primary records fail the test on exactly one criterion each: a wrong status magic, an unknown marker, or a single corrupted CRC word. The bench therefore builds every record from a CRC it computes itself, and then damages one field on purpose. Each scan is also placed so that a lower-index valid record sits below a higher-index one, which exposes any error in the search order.

// File: rtl/swap_eval_pkg.sv
package swap_eval_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_ISSUE,
        S_CAPT,
        S_CRC,
        S_EVAL,
        S_DONE
    } state_t;

    localparam logic [31:0] STAT_VALID = 32'h4321_1234;
    localparam logic [31:0] MARK_A     = 32'h0000_0055;
    localparam logic [31:0] MARK_B     = 32'h0000_00AA;
    localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
    localparam logic [3:0]  ARM_ON     = 4'b1010;

    localparam logic [1:0] CFG_NONE = 2'b00;
    localparam logic [1:0] CFG_A    = 2'b01;
    localparam logic [1:0] CFG_B    = 2'b10;

endpackage

// File: rtl/swap_crc_byte.sv
module swap_crc_byte
    import swap_eval_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);
    logic [31:0] acc;

    always_comb begin
        acc = crc_in ^ {24'h0, data};
        for (int b = 0; b < 8; b++) begin
            if (acc[0]) acc = (acc >> 1) ^ CRC_POLY_R;
            else        acc = acc >> 1;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/swap_entry_check.sv
module swap_entry_check
    import swap_eval_pkg::*;
(
    input  logic [31:0] status,
    input  logic [31:0] marker,
    input  logic [31:0] crc_acc,
    input  logic [31:0] crc_word,
    output logic        ok,
    output logic [1:0]  region
);
    logic stat_ok, crc_ok;

    always_comb begin
        stat_ok = (status == STAT_VALID);
        crc_ok  = ((crc_acc ^ CRC_SEED) == crc_word);
        if (marker == MARK_A)      region = CFG_A;
        else if (marker == MARK_B) region = CFG_B;
        else                       region = CFG_NONE;
        ok = stat_ok && crc_ok && (region != CFG_NONE);
    end
endmodule

// File: rtl/swap_cfg_eval.sv
module swap_cfg_eval
    import swap_eval_pkg::*;
#(
    parameter int          ENTRIES   = 32,
    parameter int          STRIDE    = 16,
    parameter int          ADDR_W    = 32,
    parameter int          OUT_IDX_W = 7,
    parameter logic [31:0] ORIG_BASE = 32'h0000_9800,
    parameter logic [31:0] COPY_BASE = 32'h0000_A000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [3:0]           swap_arm,
    output logic                 mem_rd,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [31:0]          mem_rdata,
    output logic [1:0]           cfg_code,
    output logic                 from_copy,
    output logic [OUT_IDX_W-1:0] win_idx,
    output logic                 done
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        state_t               st;
        logic                 tab;
        logic [IDX_W-1:0]     idx;
        logic [1:0]           word;
        logic [1:0]           bcnt;
        logic [31:0]          data;
        logic [31:0]          crc;
        logic [31:0]          stat;
        logic [31:0]          mark;
        logic                 en_ok;
        logic [1:0]           cfg;
        logic                 tab_out;
        logic [OUT_IDX_W-1:0] idx_out;
        logic                 done;
    } reg_t;

    reg_t r_q, r_d;

    logic [31:0] crc_step;
    logic        rec_ok;
    logic [1:0]  rec_region;
    logic [ADDR_W-1:0] base_sel;

    swap_crc_byte u_crc (
        .crc_in  (r_q.crc),
        .data    (r_q.data[{r_q.bcnt, 3'b000} +: 8]),
        .crc_out (crc_step)
    );

    swap_entry_check u_chk (
        .status   (r_q.stat),
        .marker   (r_q.mark),
        .crc_acc  (r_q.crc),
        .crc_word (r_q.data),
        .ok       (rec_ok),
        .region   (rec_region)
    );

    always_comb begin
        base_sel = r_q.tab ? ADDR_W'(COPY_BASE) : ADDR_W'(ORIG_BASE);
        mem_addr = base_sel + ADDR_W'(r_q.idx) * ADDR_W'(STRIDE)
                 + ADDR_W'({r_q.word, 2'b00});
        mem_rd   = (r_q.st == S_ISSUE);
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE, S_DONE: begin
                if (start) begin
                    r_d.st      = S_INIT;
                    r_d.done    = 1'b0;
                    r_d.cfg     = CFG_NONE;
                    r_d.tab_out = 1'b0;
                    r_d.idx_out = '0;
                end
            end
            S_INIT: begin
                r_d.en_ok = (swap_arm == ARM_ON);
                r_d.tab   = 1'b0;
                r_d.idx   = IDX_TOP;
                r_d.word  = 2'd0;
                r_d.crc   = CRC_SEED;
                if (swap_arm == ARM_ON) begin
                    r_d.st = S_ISSUE;
                end else begin
                    r_d.st   = S_DONE;
                    r_d.done = 1'b1;
                end
            end
            S_ISSUE: r_d.st = S_CAPT;
            S_CAPT: begin
                r_d.data = mem_rdata;
                if (r_q.word == 2'd1) r_d.stat = mem_rdata;
                if (r_q.word == 2'd2) r_d.mark = mem_rdata;
                r_d.bcnt = 2'd0;
                r_d.st   = (r_q.word == 2'd3) ? S_EVAL : S_CRC;
            end
            S_CRC: begin
                r_d.crc  = crc_step;
                r_d.bcnt = r_q.bcnt + 2'd1;
                if (r_q.bcnt == 2'd3) begin
                    r_d.word = r_q.word + 2'd1;
                    r_d.st   = S_ISSUE;
                end
            end
            S_EVAL: begin
                r_d.word = 2'd0;
                r_d.crc  = CRC_SEED;
                r_d.st   = S_ISSUE;
                if (rec_ok) begin
                    r_d.cfg     = rec_region;
                    r_d.tab_out = r_q.tab;
                    r_d.idx_out = OUT_IDX_W'(r_q.idx);
                    r_d.done    = 1'b1;
                    r_d.st      = S_DONE;
                end else if (r_q.idx != '0) begin
                    r_d.idx = r_q.idx - 1'b1;
                end else if (!r_q.tab) begin
                    r_d.tab = 1'b1;
                    r_d.idx = IDX_TOP;
                end else begin
                    r_d.done = 1'b1;
                    r_d.st   = S_DONE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_code  = r_q.cfg;
    assign from_copy = r_q.tab_out;
    assign win_idx   = r_q.idx_out;
    assign done      = r_q.done;

    assert_cfg_legal_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (cfg_code != 2'b11));
    assert_no_read_disarmed_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> r_q.en_ok);
    assert_disarmed_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !r_q.en_ok) |-> (cfg_code == CFG_NONE && !from_copy && win_idx == '0));
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(cfg_code) && $stable(win_idx)));
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);
    assert_copy_has_cfg_R7: assert property (@(posedge clk) disable iff (rst)
        (done && from_copy) |-> (cfg_code != CFG_NONE));
    assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (r_q.st == S_CAPT));

endmodule

// File: tb/sim_swap_cfg_eval.sv
module sim_swap_cfg_eval;
    localparam logic [31:0] OB = 32'h0000_9800;
    localparam logic [31:0] CB = 32'h0000_A000;
    localparam logic [31:0] OKS = 32'h4321_1234;
    localparam logic [31:0] BADS = 32'h57B5_327F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [3:0] swap_arm = 4'b1010;
    logic mem_rd;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [1:0] cfg_code;
    logic from_copy;
    logic [6:0] win_idx;
    logic done;

    int checks = 0;
    int failures = 0;
    int rd_count = 0;
    int bad_addr = 0;
    logic done_prev = 1'b0;
    logic [9:0] expq [$];

    logic [31:0] tbl [2][32][4];

    always #2.5 clk = ~clk;

    swap_cfg_eval u0 (
        .clk(clk), .rst(rst), .start(start), .swap_arm(swap_arm),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cfg_code(cfg_code), .from_copy(from_copy), .win_idx(win_idx),
        .done(done)
    );

    // memory model, one-cycle read latency (R10)
    always @(posedge clk) begin
        if (mem_rd) begin
            rd_count <= rd_count + 1;
            if (mem_addr >= OB && mem_addr < OB + 512 && mem_addr[1:0] == 2'b00)
                mem_rdata <= tbl[0][(mem_addr - OB) >> 4][(mem_addr >> 2) & 3];
            else if (mem_addr >= CB && mem_addr < CB + 512 && mem_addr[1:0] == 2'b00)
                mem_rdata <= tbl[1][(mem_addr - CB) >> 4][(mem_addr >> 2) & 3];
            else begin
                mem_rdata <= 32'hDEAD_BEEF;
                bad_addr  <= bad_addr + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        logic [95:0] m;
        logic [31:0] r;
        m = {c, b, a};
        r = 32'hFFFF_FFFF;
        for (int k = 0; k < 12; k++) begin
            r = r ^ {24'h0, m[k*8 +: 8]};
            for (int j = 0; j < 8; j++)
                r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        end
        return ~r;
    endfunction

    task automatic clear_tables();
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 32; i++)
                for (int w = 0; w < 4; w++)
                    tbl[t][i][w] = 32'h0;
    endtask

    task automatic put(input int t, input int i, input logic [31:0] st, input logic [31:0] mk);
        tbl[t][i][0] = 32'h7000_0000 + 32'(t * 4096 + i * 16);
        tbl[t][i][1] = st;
        tbl[t][i][2] = mk;
        tbl[t][i][3] = crc_ref(tbl[t][i][0], st, mk);
    endtask

    function automatic logic [9:0] model(input logic [3:0] arm);
        if (arm != 4'b1010) return 10'h0;
        for (int t = 0; t < 2; t++)
            for (int i = 31; i >= 0; i--) begin
                logic [1:0] rg;
                rg = (tbl[t][i][2] == 32'h55) ? 2'b01 : (tbl[t][i][2] == 32'hAA) ? 2'b10 : 2'b00;
                if (tbl[t][i][1] == OKS && rg != 2'b00 &&
                    tbl[t][i][3] == crc_ref(tbl[t][i][0], tbl[t][i][1], tbl[t][i][2]))
                    return {rg, t[0], 7'(i)};
            end
        return 10'h0;
    endfunction

    // monitor: compare each completed result with the scoreboard
    always @(negedge clk) begin
        done_prev <= done;
        if (done && !done_prev && !rst) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R6 unexpected result", {22'h0, cfg_code, from_copy, win_idx}, 32'h0);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                chk({cfg_code, from_copy, win_idx} == e, "R3-R8 result cfg/table/index",
                    {22'h0, cfg_code, from_copy, win_idx}, {22'h0, e});
            end
        end
    end

    task automatic run_scan(input logic [3:0] arm, input string tag);
        int n;
        int rd0;
        expq.push_back(model(arm));
        @(negedge clk);
        swap_arm = arm;
        start = 1'b1;
        rd0 = rd_count;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, {tag, " R9 start clears done"}, 32'(done), 32'h0);
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, {tag, " watchdog"}, 32'(n), 32'd5000);
        repeat (3) @(negedge clk);
        chk(done == 1'b1, {tag, " R9 done held"}, 32'(done), 32'h1);
        if (arm != 4'b1010)
            chk(rd_count == rd0, {tag, " R2 no reads when disarmed"}, 32'(rd_count - rd0), 32'h0);
    endtask

    initial begin
        clear_tables();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({done, cfg_code, from_copy, win_idx} == 11'h0, "R1 reset outputs",
            {21'h0, done, cfg_code, from_copy, win_idx}, 32'h0);
        rst = 1'b0;

        // R8 nothing valid
        run_scan(4'b1010, "R8 empty");
        // R4 region A from primary
        put(0, 5, OKS, 32'h55);
        run_scan(4'b1010, "R4 A idx5");
        // R6 highest index wins
        clear_tables(); put(0, 3, OKS, 32'hAA); put(0, 10, OKS, 32'h55);
        run_scan(4'b1010, "R6 highest");
        // R7 primary wins over copy, index 31 boundary, region B
        clear_tables(); put(0, 31, OKS, 32'hAA); put(1, 7, OKS, 32'h55);
        run_scan(4'b1010, "R7 primary first");
        // R5 corrupted CRC forces fallback to copy
        clear_tables(); put(0, 12, OKS, 32'h55); tbl[0][12][3] ^= 32'h0000_0100;
        put(1, 2, OKS, 32'hAA);
        run_scan(4'b1010, "R5 R7 bad crc fallback");
        // R3 invalid status magic, nothing else
        clear_tables(); put(0, 20, BADS, 32'h55);
        run_scan(4'b1010, "R3 invalid status");
        // R4 unknown marker rejected, index 0 boundary
        clear_tables(); put(0, 4, OKS, 32'h56); put(0, 0, OKS, 32'h55);
        run_scan(4'b1010, "R4 bad marker");
        // R7 copy at index 31 and index 0 after primary all invalid
        clear_tables(); put(0, 9, BADS, 32'hAA); put(1, 31, OKS, 32'h55); put(1, 0, OKS, 32'hAA);
        run_scan(4'b1010, "R7 copy top");
        // R2 disarmed with valid records present
        clear_tables(); put(0, 6, OKS, 32'hAA);
        run_scan(4'b0101, "R2 disarm 0101");
        run_scan(4'b0000, "R2 disarm 0000");
        // back to armed after disarmed run
        run_scan(4'b1010, "R2 rearmed");

        chk(bad_addr == 0, "R10 reads within table windows", 32'(bad_addr), 32'h0);
        chk(expq.size() == 0, "R9 every scan produced one result", 32'(expq.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule